// File: doc/BRIEF.md
# Sampled Phase Frequency Detector with Programmable Reset Delay

This block compares a reference input against a divided-feedback input inside a PLL model. Both inputs are taken as already synchronized to a fast system clock. A rising edge on the reference sets the `up_o` output. A rising edge on the feedback sets the `dn_o` output. When both outputs are high, a shared clear is issued and brings both outputs low together. The difference between the two pulse widths, counted in clock cycles, therefore equals the phase offset between the two edges.

The clear does not act at once. It waits for a number of cycles set by `rst_dly_i`, so both pulses keep a guaranteed minimum overlap even when the phase error is tiny. A charge pump that follows therefore never sees pulses too narrow to switch it fully, which avoids a dead zone. A short delay risks the dead zone again. A long delay stretches the time both pulses are active.

An input edge that arrives while the clear is pending is held. It is applied when the clear releases, so no edge is lost.

Top module: `pfd_core`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are 0 at once, without waiting for a clock edge. The overlap counter is cleared as well.
- R2: The first clock edge that samples `ref_i` at 1, after an edge that sampled it at 0, sets `up_o` to 1 right after that edge.
- R3: The first clock edge that samples `fb_i` at 1, after an edge that sampled it at 0, sets `dn_o` to 1 right after that edge.
- R4: Once `up_o` and `dn_o` are both 1, they stay 1 together for exactly `rst_dly_i`+1 cycles. Then both go to 0 on the same edge. A value of 0 therefore gives a single cycle of overlap.
- R5: When the reference edge leads the feedback edge by k cycles, `up_o` is high for k+`rst_dly_i`+1 cycles and `dn_o` is high for `rst_dly_i`+1 cycles.
- R6: When the feedback edge leads the reference edge by k cycles, `dn_o` is high for k+`rst_dly_i`+1 cycles and `up_o` is high for `rst_dly_i`+1 cycles.
- R7: When both edges are sampled on the same clock edge, both outputs are high for exactly `rst_dly_i`+1 cycles.
- R8: A rising edge on an input whose output is already high, seen while both outputs are high, is held. That output is then 1 right after the clearing edge instead of 0.
- R9: Neither output ever falls while the other output is low. Outputs fall only through the shared clear.
- R10: An input held at 1 does not set its output again. After the clear, the output stays 0 until the input goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference input, synchronized |
| fb_i | input | 1 | Divided feedback input, synchronized |
| rst_dly_i | input | DLY_W (4) | Extra overlap cycles before the shared clear |
| up_o | output | 1 | Pulse that starts on a reference edge |
| dn_o | output | 1 | Pulse that starts on a feedback edge |

## Verification
A table of edge pairs is applied, each pair with a given delay setting and a signed offset. Positive offsets show that UP widens by the lead. Negative offsets show that DOWN widens by the lag. Zero offsets show equal widths set only by the delay. The delay values include 0 and 15, which separates an off-by-one in the overlap count from an error in phase tracking. Directed cases then cover the following:
- An edge landing during a pending clear, which separates a held edge from a dropped one.
- An input held high across a clear, which separates level detection from edge detection.
- Reset asserted in the middle of a pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned DLY_W_DEF = 4;
  localparam int unsigned N_CH      = 2;
  localparam int unsigned CH_REF    = 0;
  localparam int unsigned CH_FB     = 1;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pfd_chan.sv
module pfd_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic both_i,
  input  logic clr_i,
  output logic out_o
);
  logic out_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      // a held or coincident edge restarts the pulse right after the clear
      out_q  <= pend_q | rise_i;
      pend_q <= 1'b0;
    end else if (rise_i) begin
      if (both_i) pend_q <= 1'b1;
      else        out_q  <= 1'b1;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/pfd_rst_dly.sv
module pfd_rst_dly #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             both_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             clr_o
);
  logic [DLY_W-1:0] cnt_q;

  assign clr_o = both_i && (cnt_q == dly_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!both_i || clr_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int unsigned DLY_W = pfd_pkg::DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [DLY_W-1:0] rst_dly_i,
  output logic             up_o,
  output logic             dn_o
);
  import pfd_pkg::*;

  logic [N_CH-1:0] lvl, rise, outs;
  logic            both, dly_clr;

  assign lvl[CH_REF] = ref_i;
  assign lvl[CH_FB]  = fb_i;

  pfd_edge_det #(.N(N_CH)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  assign both = &outs;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pfd_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rise_i(rise[g]),
      .both_i(both),
      .clr_i (dly_clr),
      .out_o (outs[g])
    );
  end

  pfd_rst_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .both_i(both),
    .dly_i (rst_dly_i),
    .clr_o (dly_clr)
  );

  assign up_o = outs[CH_REF];
  assign dn_o = outs[CH_FB];
endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
  parameter int unsigned DLY_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_i,
  input logic             fb_i,
  input logic [DLY_W-1:0] rst_dly_i,
  input logic             up_o,
  input logic             dn_o,
  input logic             clr_i
);
  logic [DLY_W:0] ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovl_q <= '0;
    else if (!(up_o && dn_o) || clr_i) ovl_q <= '0;
    else                           ovl_q <= ovl_q + 1'b1;
  end

  // R4
  overlap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o && ovl_q == {1'b0, rst_dly_i}) |-> clr_i);
  // R4
  overlap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |-> (ovl_q <= {1'b0, rst_dly_i}));
  // R9
  up_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_o) |-> $past(dn_o));
  // R9
  dn_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_o) |-> $past(up_o));
  // R2
  up_no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !ref_i) |=> !up_o);
  // R3
  dn_no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_o && !fb_i) |=> !dn_o);
endmodule

bind pfd_core pfd_core_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_i    (ref_i),
  .fb_i     (fb_i),
  .rst_dly_i(rst_dly_i),
  .up_o     (up_o),
  .dn_o     (dn_o),
  .clr_i    (dly_clr)
);

// File: tb/pfd_core_tb.sv
module pfd_core_tb;
  localparam int DLY_W = 4;
  localparam int NV    = 10;
  // {delay[11:8], signed offset[7:0]}; offset > 0: reference leads
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  8'sd0},  {4'd0,  8'sd3},  {4'd0,  -8'sd3}, {4'd3,  8'sd5},
    {4'd3, -8'sd2},  {4'd7,  8'sd1},  {4'd15, -8'sd6}, {4'd2,  8'sd0},
    {4'd15, 8'sd0},  {4'd1,  8'sd9}
  };

  logic clk = 0, rst_n = 0, ref_s = 0, fb_s = 0;
  logic [DLY_W-1:0] dly = '0;
  logic up, dn;
  int checks = 0, fails = 0;
  int up_w, dn_w, cyc, up_fall, dn_fall;
  logic up_d, dn_d;

  always #5 clk = ~clk;

  pfd_core #(.DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s),
    .rst_dly_i(dly), .up_o(up), .dn_o(dn)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (up) up_w <= up_w + 1;
    if (dn) dn_w <= dn_w + 1;
    if (up_d && !up) up_fall <= cyc;
    if (dn_d && !dn) dn_fall <= cyc;
    up_d <= up;
    dn_d <= dn;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int d, input int off);
    int e_up, e_dn;
    dly = d[DLY_W-1:0];
    @(negedge clk);
    up_w = 0; dn_w = 0; up_fall = -1; dn_fall = -1;
    if (off >= 0) begin
      ref_s = 1;
      if (off == 0) fb_s = 1;
      repeat (off) @(negedge clk);
      fb_s = 1;
    end else begin
      fb_s = 1;
      repeat (-off) @(negedge clk);
      ref_s = 1;
    end
    @(negedge clk); ref_s = 0; fb_s = 0;
    repeat (40) @(negedge clk);
    e_up = d + 1 + (off > 0 ? off : 0);
    e_dn = d + 1 + (off < 0 ? -off : 0);
    if (off > 0)      begin chk("R5 up width", up_w, e_up); chk("R5 dn width", dn_w, e_dn); end
    else if (off < 0) begin chk("R6 up width", up_w, e_up); chk("R6 dn width", dn_w, e_dn); end
    else              begin chk("R7 up width", up_w, e_up); chk("R7 dn width", dn_w, e_dn); end
    chk("R4 R9 common fall", up_fall, dn_fall);
  endtask

  initial begin
    cyc = 0; up_w = 0; dn_w = 0; up_d = 0; dn_d = 0; up_fall = -1; dn_fall = -1;
    #12;
    chk("R1 reset up", int'(up), 0);
    chk("R1 reset dn", int'(dn), 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 / R3: one-edge latency
    ref_s = 1;
    chk("R2 up before edge", int'(up), 0);
    @(negedge clk);
    chk("R2 up after edge", int'(up), 1);
    fb_s = 1;
    @(negedge clk);
    chk("R3 dn after edge", int'(dn), 1);
    ref_s = 0; fb_s = 0;
    repeat (20) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_vec(int'(VEC[i][11:8]), int'($signed(VEC[i][7:0])));

    // R8: reference edge during pending clear is held
    dly = 4'd5;
    @(negedge clk); ref_s = 1;
    @(negedge clk); fb_s = 1;
    @(negedge clk); ref_s = 0; fb_s = 0;
    @(negedge clk); ref_s = 1;           // both high, clear pending
    @(negedge clk); ref_s = 0;
    repeat (10) @(negedge clk);
    chk("R8 up reasserted after clear", int'(up), 1);
    chk("R8 dn cleared", int'(dn), 0);
    fb_s = 1;
    @(negedge clk); fb_s = 0;
    repeat (20) @(negedge clk);
    chk("R8 pair cleared", int'(up | dn), 0);

    // R10: level held high does not retrigger
    dly = 4'd0;
    ref_s = 1;
    @(negedge clk); fb_s = 1;
    @(negedge clk); fb_s = 0;
    repeat (10) @(negedge clk);
    chk("R10 up stays low with ref held", int'(up), 0);
    ref_s = 0;
    @(negedge clk); ref_s = 1;
    @(negedge clk);
    chk("R10 up set on new edge", int'(up), 1);
    ref_s = 0;

    // R1: asynchronous reset mid-pulse
    #2 rst_n = 0;
    #1;
    chk("R1 async clear up", int'(up), 0);
    chk("R1 async clear dn", int'(dn), 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(up | dn), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule